// File: doc/BRIEF.md
# Binary Lamp Memory Viewer

This block draws a 256-byte debug memory window on a VGA monitor as rows of virtual front-panel lamps. Each byte becomes eight square lamps side by side. A lamp is lit when its bit is 1 and dim when its bit is 0. The whole window is sixteen rows of sixteen bytes, starting at address 0. A hexadecimal digit over each byte column and beside each byte row lets the viewer find a byte quickly.

The block has its own pixel and line counters, which run on the pixel clock (108 MHz at the default 1280x1024 timing). From the screen position it derives which byte is under the beam and which bit of that byte a lamp stands for, and it issues reads to the display port of a dual-clock RAM. Logic under debug writes that RAM from its own slow clock domain. The RAM answers two cycles after the address, so the block carries the position context of each pixel along a delay line and meets the returning byte there. The RAM, the DAC and clock generation sit outside the block.

Top module: `binlamp_view`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `red`, `green`, `blue`, `hsync`, `vsync` and `rd_en` all at 0.
- R2: A line lasts `H_TOTAL` clocks and a frame lasts `V_TOTAL` lines. `hsync` is high (active high) for counter columns `H_ACTIVE+H_FP` up to `H_ACTIVE+H_FP+H_SYNC-1`, and `vsync` is high for lines `V_ACTIVE+V_FP` up to `V_ACTIVE+V_FP+V_SYNC-1`. The outputs for counter position n leave on the fourth clock edge after that position is reached, so after reset release position (0,0) appears on edge 4, and edges 1 to 3 carry black with both syncs low.
- R3: Every pixel outside the 1280x1024 visible area (in general, `H_ACTIVE` by `V_ACTIVE`), and every visible pixel that is not a lamp or a label stroke, is black (12'h000).
- R4: Let P = 8*L+GAP, where L = 2^LAMP_LOG2. For a visible pixel with ORG_X <= x < ORG_X+16*P and ORG_Y <= y < ORG_Y+16*ROW_PITCH, take c = (x-ORG_X)/P and r = (y-ORG_Y)/ROW_PITCH. When (x-ORG_X)%P < 8*L and (y-ORG_Y)%ROW_PITCH < L, the edge after that position drives `rd_en`=1 and `rd_addr`=16*r+c. At every other position `rd_en` is 0.
- R5: Inside byte (r,c), lamp j = ((x-ORG_X)%P)/L counts 0 to 7 from the left and shows bit 7-j of the byte. An interior lamp pixel is {red,green,blue}=12'hFA0 for a 1 bit and 12'h320 for a 0 bit.
- R6: The outermost `BORDER` pixels of each lamp, on all four sides, are black.
- R7: The block samples `rd_data` on the third edge after the edge that presented `rd_addr`. The lamp colour must come from the byte at that address and not from a neighbouring byte.
- R8: Above byte column c, an 8x8 label cell with its top-left corner at x = ORG_X+c*P, y = ORG_Y-16 shows hex digit c, in white (12'hFFF) on black.
- R9: To the left of byte row r, an 8x8 label cell with its top-left corner at x = ORG_X-16, y = ORG_Y+r*ROW_PITCH shows hex digit r, in white on black.
- R10: Digits are seven-segment shapes inside the 8x8 cell, with gx and gy measured from the top-left corner. The segments are: a is row 0; g is row 3; d is row 6; each of these spans columns 1 to 5. f is column 1, rows 0 to 3. e is column 1, rows 3 to 6. b is column 5, rows 0 to 3. c is column 5, rows 3 to 6. Segment code bits are {g,f,e,d,c,b,a}, and the codes for 0 to F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | output | 1 | Read strobe to the display port of the RAM |
| rd_addr | output | 8 | Byte address, {row, column} |
| rd_data | input | 8 | RAM reply, two cycles after the address |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| red | output | 4 | Red level |
| green | output | 4 | Green level |
| blue | output | 4 | Blue level |

## Verification
The block issues reads and draws lamps in the same cycle: while the lamp colour of an older pixel is being formed from the returning byte, a read for a newer pixel is already going out. At every byte boundary the outgoing address changes while the last lamp of the previous byte is still waiting for its data. The bench fills the RAM with a permutation, so neighbouring bytes always differ. It then compares every pixel and every read strobe of a full frame plus two lines against an independent model of the geometry. A pipeline that is one cycle short or long therefore shows up as a wrong colour at a lamp edge or a byte edge. The frame wrap puts the sync pulses and the first reads of the new frame in flight together, and this is judged by the same comparison.

// File: rtl/binlamp_view.sv
`timescale 1ns/1ps
module binlamp_view #(
  parameter int H_ACTIVE  = 1280,
  parameter int H_FP      = 48,
  parameter int H_SYNC    = 112,
  parameter int H_TOTAL   = 1688,
  parameter int V_ACTIVE  = 1024,
  parameter int V_FP      = 1,
  parameter int V_SYNC    = 3,
  parameter int V_TOTAL   = 1066,
  parameter int LAMP_LOG2 = 3,
  parameter int BORDER    = 1,
  parameter int GAP       = 8,
  parameter int ROW_PITCH = 16,
  parameter int ORG_X     = 64,
  parameter int ORG_Y     = 64,
  parameter int RD_LAT    = 2
) (
  input  logic       clk,
  input  logic       rst,
  output logic       rd_en,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data,
  output logic       hsync,
  output logic       vsync,
  output logic [3:0] red,
  output logic [3:0] green,
  output logic [3:0] blue
);
  localparam int LAMP  = 1 << LAMP_LOG2;
  localparam int PITCH = 8 * LAMP + GAP;
  localparam int HW    = $clog2(H_TOTAL);
  localparam int VW    = $clog2(V_TOTAL);
  localparam int CW    = 7;

  localparam logic [15:0] X0  = 16'(ORG_X);
  localparam logic [15:0] Y0  = 16'(ORG_Y);
  localparam logic [15:0] XE  = 16'(ORG_X + 16 * PITCH);
  localparam logic [15:0] YE  = 16'(ORG_Y + 16 * ROW_PITCH);
  localparam logic [15:0] XP  = 16'(PITCH);
  localparam logic [15:0] YP  = 16'(ROW_PITCH);
  localparam logic [15:0] XL  = 16'(ORG_X - 16);
  localparam logic [15:0] YL  = 16'(ORG_Y - 16);
  localparam logic [15:0] LW  = 16'(8 * LAMP);
  localparam logic [15:0] LS  = 16'(LAMP);
  localparam logic [15:0] BD  = 16'(BORDER);
  localparam logic [15:0] HA  = 16'(H_ACTIVE);
  localparam logic [15:0] VA  = 16'(V_ACTIVE);
  localparam logic [15:0] HS0 = 16'(H_ACTIVE + H_FP);
  localparam logic [15:0] HS1 = 16'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [15:0] VS0 = 16'(V_ACTIVE + V_FP);
  localparam logic [15:0] VS1 = 16'(V_ACTIVE + V_FP + V_SYNC);

  localparam logic [11:0] C_LIT   = 12'hFA0;
  localparam logic [11:0] C_DIM   = 12'h320;
  localparam logic [11:0] C_WHITE = 12'hFFF;

  function automatic logic glyph(input logic [3:0] d, input logic [2:0] gx, input logic [2:0] gy);
    logic [6:0] s;
    logic span, up, dn;
    case (d)
      4'h0: s = 7'h3F;  4'h1: s = 7'h06;  4'h2: s = 7'h5B;  4'h3: s = 7'h4F;
      4'h4: s = 7'h66;  4'h5: s = 7'h6D;  4'h6: s = 7'h7D;  4'h7: s = 7'h07;
      4'h8: s = 7'h7F;  4'h9: s = 7'h6F;  4'hA: s = 7'h77;  4'hB: s = 7'h7C;
      4'hC: s = 7'h39;  4'hD: s = 7'h5E;  4'hE: s = 7'h79;  4'hF: s = 7'h71;
    endcase
    span = gx >= 3'd1 && gx <= 3'd5;
    up   = gy <= 3'd3;
    dn   = gy >= 3'd3 && gy <= 3'd6;
    return (s[0] && gy == 3'd0 && span) || (s[1] && gx == 3'd5 && up) ||
           (s[2] && gx == 3'd5 && dn)   || (s[3] && gy == 3'd6 && span) ||
           (s[4] && gx == 3'd1 && dn)   || (s[5] && gx == 3'd1 && up) ||
           (s[6] && gy == 3'd3 && span);
  endfunction

  logic [HW-1:0] hc;
  logic [VW-1:0] vc;

  always_ff @(posedge clk) begin
    if (rst) begin
      hc <= '0;
      vc <= '0;
    end else if (hc == HW'(H_TOTAL - 1)) begin
      hc <= '0;
      vc <= (vc == VW'(V_TOTAL - 1)) ? '0 : vc + 1'b1;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  logic [15:0] x, y, rx, ry, xo, yo, lx;
  logic [3:0]  col, row;
  logic [2:0]  lj;
  logic        in_x, in_y, lamp_hit, rim, clab, rlab, glyph_px, active;
  logic [CW-1:0] ctx_in;

  assign x   = 16'(hc);
  assign y   = 16'(vc);
  assign rx  = x - X0;
  assign ry  = y - Y0;
  assign xo  = rx % XP;
  assign yo  = ry % YP;
  assign col = 4'(rx / XP);
  assign row = 4'(ry / YP);
  assign lx  = xo & (LS - 16'd1);
  assign lj  = 3'(xo >> LAMP_LOG2);

  assign in_x     = x >= X0 && x < XE;
  assign in_y     = y >= Y0 && y < YE;
  assign active   = x < HA && y < VA;
  assign lamp_hit = in_x && in_y && xo < LW && yo < LS;
  assign rim      = lx < BD || lx >= LS - BD || yo < BD || yo >= LS - BD;
  assign clab     = in_x && y >= YL && y < YL + 16'd8 && xo < 16'd8;
  assign rlab     = in_y && x >= XL && x < XL + 16'd8 && yo < 16'd8;
  assign glyph_px = clab ? glyph(col, 3'(xo), 3'(y - YL)) :
                    rlab ? glyph(row, 3'(x - XL), 3'(yo)) : 1'b0;

  assign ctx_in = {x >= HS0 && x < HS1, y >= VS0 && y < VS1,
                   active && lamp_hit && !rim, active && glyph_px, 3'd7 - lj};

  logic [CW-1:0] ctx [RD_LAT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= RD_LAT; i++) ctx[i] <= '0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
    end else begin
      ctx[0] <= ctx_in;
      for (int i = 1; i <= RD_LAT; i++) ctx[i] <= ctx[i-1];
      rd_en   <= active && lamp_hit;
      rd_addr <= {row, col};
    end
  end

  logic [CW-1:0] tl;
  assign tl = ctx[RD_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= 1'b0;
      vsync <= 1'b0;
      {red, green, blue} <= '0;
    end else begin
      hsync <= tl[6];
      vsync <= tl[5];
      {red, green, blue} <= tl[4] ? (rd_data[tl[2:0]] ? C_LIT : C_DIM) :
                            tl[3] ? C_WHITE : 12'h000;
    end
  end
endmodule

// File: rtl/binlamp_view_chk.sv
`timescale 1ns/1ps
module binlamp_view_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_en,
  input logic [7:0] rd_addr,
  input logic       hsync,
  input logic       vsync,
  input logic [3:0] red,
  input logic [3:0] green,
  input logic [3:0] blue
);
  logic [11:0] rgb;
  logic        rst_q;
  assign rgb = {red, green, blue};

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk)
    if (rst_q)
      a_r1_quiet_after_reset: assert (rgb == 12'h000 && !hsync && !vsync && !rd_en)
        else $error("reset did not clear outputs");

  a_r3_black_in_sync: assert property (@(posedge clk) disable iff (rst)
    (hsync || vsync) |-> rgb == 12'h000);

  a_r5_palette_only: assert property (@(posedge clk) disable iff (rst)
    rgb == 12'h000 || rgb == 12'hFA0 || rgb == 12'h320 || rgb == 12'hFFF);

  a_r4_steady_byte_addr: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> rd_addr == $past(rd_addr));

  a_r7_lamp_after_read: assert property (@(posedge clk) disable iff (rst)
    (rgb == 12'hFA0 || rgb == 12'h320) |-> $past(rd_en, 3));
endmodule

bind binlamp_view binlamp_view_chk u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
  .hsync(hsync), .vsync(vsync), .red(red), .green(green), .blue(blue)
);

// File: tb/tb_binlamp_view.sv
`timescale 1ns/1ps
module tb_binlamp_view;
  localparam int HA = 600, HFP = 8, HSW = 16, HT = 640;
  localparam int VA = 210, VFP = 1, VSW = 2, VT = 215;
  localparam int LL2 = 2, L = 4, BRD = 1, GP = 4, RP = 12, OX = 16, OY = 16;
  localparam int PITCH = 8 * L + GP;
  localparam int NPIX = HT * VT + 2 * HT;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_en, hsync, vsync;
  logic [7:0] rd_addr;
  logic [7:0] rd_data = 8'h00;
  logic [3:0] red, green, blue;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0]  mem [256];
  logic [7:0]  a1 = 8'h00;
  logic [17:0] q_px [$];
  logic [8:0]  q_rd [$];

  always #4 clk = ~clk;

  binlamp_view #(
    .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HSW), .H_TOTAL(HT),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VSW), .V_TOTAL(VT),
    .LAMP_LOG2(LL2), .BORDER(BRD), .GAP(GP), .ROW_PITCH(RP),
    .ORG_X(OX), .ORG_Y(OY), .RD_LAT(2)
  ) dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .hsync(hsync), .vsync(vsync), .red(red), .green(green), .blue(blue)
  );

  // RAM display port: two cycles from address to data
  always @(posedge clk) begin
    a1      <= rd_addr;
    rd_data <= mem[a1];
  end

  // R10: seven-segment shapes
  function automatic logic seg7(input int d, input int gx, input int gy);
    logic [6:0] s;
    case (d)
      0: s = 7'h3F;  1: s = 7'h06;  2: s = 7'h5B;  3: s = 7'h4F;
      4: s = 7'h66;  5: s = 7'h6D;  6: s = 7'h7D;  7: s = 7'h07;
      8: s = 7'h7F;  9: s = 7'h6F;  10: s = 7'h77; 11: s = 7'h7C;
      12: s = 7'h39; 13: s = 7'h5E; 14: s = 7'h79; default: s = 7'h71;
    endcase
    return (s[0] && gy == 0 && gx >= 1 && gx <= 5) ||
           (s[6] && gy == 3 && gx >= 1 && gx <= 5) ||
           (s[3] && gy == 6 && gx >= 1 && gx <= 5) ||
           (s[5] && gx == 1 && gy <= 3) || (s[4] && gx == 1 && gy >= 3 && gy <= 6) ||
           (s[1] && gx == 5 && gy <= 3) || (s[2] && gx == 5 && gy >= 3 && gy <= 6);
  endfunction

  task automatic model(input int n, output logic [17:0] px, output logic [8:0] rd);
    int x, y, c, r, xo, yo, j, lx, tag;
    logic hs, vs, en;
    logic [11:0] col;
    x = n % HT;
    y = (n / HT) % VT;
    hs = x >= HA + HFP && x < HA + HFP + HSW;   // R2
    vs = y >= VA + VFP && y < VA + VFP + VSW;
    col = 12'h000; en = 1'b0; c = 0; r = 0;
    tag = (hs || vs) ? 2 : 3;                   // R3 default black
    if (x < HA && y < VA) begin
      if (x >= OX && x < OX + 16 * PITCH) begin
        c = (x - OX) / PITCH; xo = (x - OX) % PITCH;
        if (y >= OY && y < OY + 16 * RP) begin
          r = (y - OY) / RP; yo = (y - OY) % RP;
          if (xo < 8 * L && yo < L) begin       // R4 lamp area
            en = 1'b1;
            j = xo / L; lx = xo % L;
            if (lx < BRD || lx >= L - BRD || yo < BRD || yo >= L - BRD) tag = 6;   // R6
            else begin
              tag = 5;                          // R5 / R7
              col = mem[r * 16 + c][7 - j] ? 12'hFA0 : 12'h320;
            end
          end
        end else if (y >= OY - 16 && y < OY - 8 && xo < 8) begin
          tag = 8;                              // R8 column digit
          col = seg7(c, xo, y - (OY - 16)) ? 12'hFFF : 12'h000;
        end
      end
      if (x >= OX - 16 && x < OX - 8 && y >= OY && y < OY + 16 * RP) begin
        r = (y - OY) / RP; yo = (y - OY) % RP;
        if (yo < 8) begin
          tag = 9;                              // R9 row digit
          col = seg7(r, x - (OX - 16), yo) ? 12'hFFF : 12'h000;
        end
      end
    end
    px = {4'(tag), hs, vs, col};
    rd = {en, 8'(r * 16 + c)};
  endtask

  task automatic drive_frame();
    logic [17:0] px;
    logic [8:0]  rd;
    for (int n = 0; n < NPIX; n++) begin
      model(n, px, rd);
      q_px.push_back(px);
      q_rd.push_back(rd);
    end
  endtask

  task automatic check_quiet(input string why);
    total++;
    if ({red, green, blue} !== 12'h000 || hsync !== 1'b0 || vsync !== 1'b0 || rd_en !== 1'b0) begin
      bad++;
      $display("FAIL R1 %s: got rgb=%h hs=%b vs=%b en=%b expected all zero",
               why, {red, green, blue}, hsync, vsync, rd_en);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_quiet("held reset");
    drive_frame();
    rst = 1'b0;
    // monitor: read port one edge after the position, pixels four edges after (R7, R2)
    for (int k = 1; q_px.size() > 0; k++) begin
      logic [17:0] p;
      logic [8:0]  e;
      @(posedge clk);
      @(negedge clk);
      if (q_rd.size() > 0) begin
        e = q_rd.pop_front();
        total++;
        if (rd_en !== e[8] || (e[8] && rd_addr !== e[7:0])) begin
          bad++;
          $display("FAIL R4 read port: got en=%b addr=%h expected en=%b addr=%h",
                   rd_en, rd_addr, e[8], e[7:0]);
        end
      end
      if (k <= 3) begin
        total++;
        if ({hsync, vsync, red, green, blue} !== 14'h0) begin
          bad++;
          $display("FAIL R2 edge %0d after release: got %h expected 0", k,
                   {hsync, vsync, red, green, blue});
        end
      end else begin
        p = q_px.pop_front();
        total++;
        if ({hsync, vsync, red, green, blue} !== p[13:0]) begin
          bad++;
          $display("FAIL R%0d pixel %0d: got hs=%b vs=%b rgb=%h expected hs=%b vs=%b rgb=%h",
                   p[17:14], k - 4, hsync, vsync, {red, green, blue}, p[13], p[12], p[11:0]);
        end
      end
    end
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_quiet("reset mid-frame");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog: pending pixels=%0d expected 0", q_px.size());
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule